// File: doc/BRIEF.md
# SWD Transaction Sequencer

This block carries out one complete Serial Wire Debug access. It sits above a bit engine that produces the actual clock and data timing. The sequencer does not toggle pins itself. It hands the engine a series of commands. Each command either drives a number of bits (1 to 32) or samples that many bits. The sequencer waits for the engine to report that a command has finished before it issues the next one.

An access is started with an 8-bit request byte, a 32-bit write value and three settings: the turnaround length, the number of idle clocks, and a flag that forces a data phase after a WAIT or FAULT answer. The sequencer then runs these phases in order:
- it sends the request;
- it turns the line around and collects the acknowledge;
- it runs the data phase that the acknowledge calls for;
- it ends with idle clocks or a recovery sequence.

When it finishes, it reports the acknowledge code, the read word and a read-parity error flag.

Top module: `swd_txn_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o`, `cmd_valid_o` and `perr_o` are 0, and `ack_o` and `rdata_o` are all zeros.
- R2: A `start_i` accepted while idle latches all inputs and loads a driven 8-bit command carrying `req_i` (bit 0 goes out first). It is issued on the next clock.
- R3: After the request, the block samples `turn_i`+4 bits, which is the turnaround length T=`turn_i`+1 plus 3. The acknowledge is bits [T+2:T] of that response. The codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100, and `ack_o` shows the raw code.
- R4: For OK with request bit 2 set (read), the block samples 32 data bits, then 1 parity bit, then T turnaround bits. `rdata_o` then holds the data word. For every other outcome `rdata_o` is 0.
- R5: If the read parity bit differs from the XOR of the 32 data bits, `perr_o` is 1 and `ack_o` is 3'b000.
- R6: For OK with request bit 2 clear (write), the block samples T turnaround bits, then drives the 32-bit write word, then drives 1 bit equal to the XOR of that word.
- R7: After an OK access the block drives zeros for `idle_i` clocks, in commands of at most 32 bits each. It issues no idle command when `idle_i` is 0.
- R8: On WAIT or FAULT with `force_dp_i` set, a read samples 32+1 dummy bits and then T bits. A write samples T bits and then drives 32 zero bits and one zero bit.
- R9: On WAIT or FAULT with `force_dp_i` clear, the block samples only T turnaround bits and then finishes with no idle clocks.
- R10: On any other acknowledge value, the block samples 32 bits and then T+1 bits, which backs off a full data phase, and then finishes.
- R11: `done_o` is high for exactly one cycle, on the clock after the engine completes the last command. `busy_o` is high from the clock after an accepted start through the `done_o` cycle.
- R12: A `start_i` while busy is ignored. The running access is unaffected, and no new access follows it.
- R13: Engine interface: `cmd_len_o` is the bit count minus 1, and `cmd_drive_o`=1 means driven. Sampled bits arrive on `cmd_rdata_i` with the first bit in bit 0, qualified by a one-cycle `cmd_done_i`. Command fields stay constant while `cmd_valid_o` is high and no completion has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an access |
| req_i | input | 8 | Request byte; bit 2 set selects read |
| wdata_i | input | 32 | Write word |
| turn_i | input | TURN_W | Turnaround length minus 1 |
| idle_i | input | IDLE_W | Idle clocks after an OK access |
| force_dp_i | input | 1 | Force a data phase on WAIT/FAULT |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 3 | Acknowledge, or 3'b000 on parity error |
| rdata_o | output | 32 | Read word |
| perr_o | output | 1 | Read parity mismatch |
| cmd_valid_o | output | 1 | Command present for the bit engine |
| cmd_drive_o | output | 1 | 1: drive bits, 0: sample bits |
| cmd_len_o | output | 5 | Bit count minus 1 |
| cmd_data_o | output | 32 | Bits to drive, first bit in bit 0 |
| cmd_done_i | input | 1 | Engine finished the current command |
| cmd_rdata_i | input | 32 | Sampled bits, valid with cmd_done_i |

## Verification
A new command appears on the falling edge after the clock that registered the previous completion. The bench therefore reads the command fields at the first falling edge where `cmd_valid_o` is high. It reads them again just before it raises `cmd_done_i`, after a random delay of 0 to 2 cycles. `done_o` is due exactly one clock after the last completion. The bench records the cycle number of that completion and compares it when it sees the pulse, and it reads `ack_o`, `rdata_o` and `perr_o` on that same falling edge. `busy_o` must be low one falling edge later, and it must stay low for three more cycles after an ignored start.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  localparam int WORD_W  = 32;
  localparam int REQ_W   = 8;
  localparam int ACK_W   = 3;
  localparam int LEN_W   = $clog2(WORD_W);
  localparam int RNW_BIT = 2;

  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;
  localparam logic [ACK_W-1:0] ACK_PERR  = 3'b000;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_ACK, S_RDAT, S_RPAR, S_TRN,
    S_WDAT, S_WPAR, S_IDLC, S_BOA, S_BOB, S_FIN
  } seq_state_e;
endpackage

// File: rtl/swd_seq_fsm.sv
module swd_seq_fsm
  import swd_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_done_i,
  input  logic [ACK_W-1:0] ack_now_i,
  input  logic             rnw_i,
  input  logic             force_i,
  input  logic             idle_zero_i,
  input  logic             idle_last_i,
  output seq_state_e       state_o,
  output logic             ok_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;
  logic ok_q;
  logic ok_now, wf_now;

  assign ok_now = (ack_now_i == ACK_OK);
  assign wf_now = (ack_now_i == ACK_WAIT) || (ack_now_i == ACK_FAULT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_REQ;
      S_REQ:  if (cmd_done_i) state_d = S_ACK;
      S_ACK:
        if (cmd_done_i) begin
          if (ok_now || wf_now)
            state_d = (rnw_i && (ok_now || force_i)) ? S_RDAT : S_TRN;
          else
            state_d = S_BOA;
        end
      S_RDAT: if (cmd_done_i) state_d = S_RPAR;
      S_RPAR: if (cmd_done_i) state_d = S_TRN;
      S_TRN:
        if (cmd_done_i) begin
          if (ok_q)
            state_d = !rnw_i ? S_WDAT : (idle_zero_i ? S_FIN : S_IDLC);
          else
            state_d = (!rnw_i && force_i) ? S_WDAT : S_FIN;
        end
      S_WDAT: if (cmd_done_i) state_d = S_WPAR;
      S_WPAR:
        if (cmd_done_i) state_d = (ok_q && !idle_zero_i) ? S_IDLC : S_FIN;
      S_IDLC: if (cmd_done_i && idle_last_i) state_d = S_FIN;
      S_BOA:  if (cmd_done_i) state_d = S_BOB;
      S_BOB:  if (cmd_done_i) state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_ACK && cmd_done_i) ok_q <= ok_now;
    end
  end

  assign state_o = state_q;
  assign ok_o    = ok_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_FIN);
endmodule

// File: rtl/swd_seq_dpath.sv
module swd_seq_dpath
  import swd_seq_pkg::*;
#(
  parameter int IDLE_W    = 8,
  parameter int TURN_W    = 2,
  parameter int CHUNK_MAX = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  seq_state_e        state_i,
  input  logic              cmd_done_i,
  input  logic [WORD_W-1:0] rsp_i,
  input  logic              ok_i,
  input  logic [REQ_W-1:0]  req_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [TURN_W-1:0] turn_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              force_i,
  output logic [REQ_W-1:0]  req_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [TURN_W-1:0] turn_o,
  output logic              rnw_o,
  output logic              force_o,
  output logic [ACK_W-1:0]  ack_now_o,
  output logic              idle_zero_o,
  output logic              idle_last_o,
  output logic [LEN_W-1:0]  chunk_len_o,
  output logic [ACK_W-1:0]  ack_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              perr_o
);
  logic [REQ_W-1:0]  req_q;
  logic [WORD_W-1:0] wdata_q, rdata_q, ack_sh;
  logic [TURN_W-1:0] turn_q;
  logic [IDLE_W-1:0] idle_rem_q, chunk;
  logic              force_q, perr_q;
  logic [ACK_W-1:0]  ack_q;

  // ack sits above the T turnaround bits, T = turn_q + 1
  assign ack_sh      = rsp_i >> (int'(turn_q) + 1);
  assign ack_now_o   = ack_sh[ACK_W-1:0];
  assign idle_zero_o = (idle_rem_q == '0);
  assign idle_last_o = (idle_rem_q <= IDLE_W'(CHUNK_MAX));
  assign chunk       = idle_last_o ? idle_rem_q : IDLE_W'(CHUNK_MAX);
  assign chunk_len_o = LEN_W'(chunk - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= '0;
      wdata_q    <= '0;
      turn_q     <= '0;
      idle_rem_q <= '0;
      force_q    <= 1'b0;
      rdata_q    <= '0;
      perr_q     <= 1'b0;
      ack_q      <= '0;
    end else begin
      if (load_i) begin
        req_q      <= req_i;
        wdata_q    <= wdata_i;
        turn_q     <= turn_i;
        idle_rem_q <= idle_i;
        force_q    <= force_i;
        rdata_q    <= '0;
        perr_q     <= 1'b0;
        ack_q      <= '0;
      end
      if (cmd_done_i) begin
        case (state_i)
          S_ACK:  ack_q <= ack_now_o;
          S_RDAT: if (ok_i) rdata_q <= rsp_i;
          S_RPAR:
            if (ok_i && (rsp_i[0] != ^rdata_q)) begin
              perr_q <= 1'b1;
              ack_q  <= ACK_PERR;
            end
          S_IDLC: idle_rem_q <= idle_rem_q - chunk;
          default: ;
        endcase
      end
    end
  end

  assign req_o   = req_q;
  assign wdata_o = wdata_q;
  assign turn_o  = turn_q;
  assign rnw_o   = req_q[RNW_BIT];
  assign force_o = force_q;
  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
  assign perr_o  = perr_q;
endmodule

// File: rtl/swd_seq_cmd.sv
module swd_seq_cmd
  import swd_seq_pkg::*;
#(
  parameter int TURN_W = 2
) (
  input  seq_state_e        state_i,
  input  logic              ok_i,
  input  logic [REQ_W-1:0]  req_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [TURN_W-1:0] turn_i,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic              valid_o,
  output logic              drive_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [LEN_W-1:0] WORD_LEN = LEN_W'(WORD_W - 1);

  always_comb begin
    valid_o = 1'b1;
    drive_o = 1'b0;
    len_o   = '0;
    data_o  = '0;
    case (state_i)
      S_REQ: begin
        drive_o = 1'b1;
        len_o   = LEN_W'(REQ_W - 1);
        data_o  = WORD_W'(req_i);
      end
      S_ACK:  len_o = LEN_W'(turn_i) + LEN_W'(ACK_W);
      S_RDAT: len_o = WORD_LEN;
      S_RPAR: len_o = '0;
      S_TRN:  len_o = LEN_W'(turn_i);
      S_WDAT: begin
        drive_o = 1'b1;
        len_o   = WORD_LEN;
        data_o  = ok_i ? wdata_i : '0;  // dummy phase sends zeros
      end
      S_WPAR: begin
        drive_o = 1'b1;
        data_o  = WORD_W'(ok_i && (^wdata_i));
      end
      S_IDLC: begin
        drive_o = 1'b1;
        len_o   = chunk_len_i;
      end
      S_BOA:  len_o = WORD_LEN;
      S_BOB:  len_o = LEN_W'(turn_i) + LEN_W'(1);
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/swd_txn_seq.sv
module swd_txn_seq
  import swd_seq_pkg::*;
#(
  parameter int IDLE_W    = 8,
  parameter int TURN_W    = 2,
  parameter int CHUNK_MAX = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REQ_W-1:0]  req_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [TURN_W-1:0] turn_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              force_dp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ACK_W-1:0]  ack_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              perr_o,
  output logic              cmd_valid_o,
  output logic              cmd_drive_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [WORD_W-1:0] cmd_data_o,
  input  logic              cmd_done_i,
  input  logic [WORD_W-1:0] cmd_rdata_i
);
  seq_state_e        state;
  logic              ok, rnw, force_q, idle_zero, idle_last, load;
  logic [ACK_W-1:0]  ack_now;
  logic [REQ_W-1:0]  req_q;
  logic [WORD_W-1:0] wdata_q;
  logic [TURN_W-1:0] turn_q;
  logic [LEN_W-1:0]  chunk_len;

  assign load = start_i && !busy_o;

  swd_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cmd_done_i  (cmd_done_i),
    .ack_now_i   (ack_now),
    .rnw_i       (rnw),
    .force_i     (force_q),
    .idle_zero_i (idle_zero),
    .idle_last_i (idle_last),
    .state_o     (state),
    .ok_o        (ok),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  swd_seq_dpath #(
    .IDLE_W    (IDLE_W),
    .TURN_W    (TURN_W),
    .CHUNK_MAX (CHUNK_MAX)
  ) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .state_i     (state),
    .cmd_done_i  (cmd_done_i),
    .rsp_i       (cmd_rdata_i),
    .ok_i        (ok),
    .req_i       (req_i),
    .wdata_i     (wdata_i),
    .turn_i      (turn_i),
    .idle_i      (idle_i),
    .force_i     (force_dp_i),
    .req_o       (req_q),
    .wdata_o     (wdata_q),
    .turn_o      (turn_q),
    .rnw_o       (rnw),
    .force_o     (force_q),
    .ack_now_o   (ack_now),
    .idle_zero_o (idle_zero),
    .idle_last_o (idle_last),
    .chunk_len_o (chunk_len),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .perr_o      (perr_o)
  );

  swd_seq_cmd #(.TURN_W(TURN_W)) u_cmd (
    .state_i     (state),
    .ok_i        (ok),
    .req_i       (req_q),
    .wdata_i     (wdata_q),
    .turn_i      (turn_q),
    .chunk_len_i (chunk_len),
    .valid_o     (cmd_valid_o),
    .drive_o     (cmd_drive_o),
    .len_o       (cmd_len_o),
    .data_o      (cmd_data_o)
  );
endmodule

// File: rtl/swd_txn_seq_chk.sv
module swd_txn_seq_chk
  import swd_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [REQ_W-1:0]  req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ACK_W-1:0]  ack_o,
  input logic              perr_o,
  input logic              cmd_valid_o,
  input logic              cmd_drive_o,
  input logic [LEN_W-1:0]  cmd_len_o,
  input logic [WORD_W-1:0] cmd_data_o,
  input logic              cmd_done_i
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  // R2
  req_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> cmd_valid_o && cmd_drive_o && cmd_len_o == LEN_W'(REQ_W - 1)
                           && cmd_data_o[REQ_W-1:0] == $past(req_i));

  // R13
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_drive_o)
                                   && $stable(cmd_len_o) && $stable(cmd_data_o));

  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  // R5
  perr_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && perr_o |-> ack_o == ACK_PERR);
endmodule

bind swd_txn_seq swd_txn_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ack_o       (ack_o),
  .perr_o      (perr_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_drive_o (cmd_drive_o),
  .cmd_len_o   (cmd_len_o),
  .cmd_data_o  (cmd_data_o),
  .cmd_done_i  (cmd_done_i)
);

// File: tb/swd_txn_seq_test.sv
`timescale 1ns/1ps
module swd_txn_seq_test;
  import swd_seq_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        req = '0;
  logic [31:0]       wdata = '0;
  logic [1:0]        turn = '0;
  logic [7:0]        idle = '0;
  logic              force_dp = 1'b0;
  logic              busy, done, perr;
  logic [2:0]        ack;
  logic [31:0]       rdata;
  logic              cmd_valid, cmd_drive;
  logic [LEN_W-1:0]  cmd_len;
  logic [31:0]       cmd_data;
  logic              cmd_done = 1'b0;
  logic [31:0]       cmd_rdata = '0;

  swd_txn_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req), .wdata_i(wdata),
    .turn_i(turn), .idle_i(idle), .force_dp_i(force_dp), .busy_o(busy), .done_o(done),
    .ack_o(ack), .rdata_o(rdata), .perr_o(perr), .cmd_valid_o(cmd_valid),
    .cmd_drive_o(cmd_drive), .cmd_len_o(cmd_len), .cmd_data_o(cmd_data),
    .cmd_done_i(cmd_done), .cmd_rdata_i(cmd_rdata)
  );

  int     n_chk = 0, n_bad = 0;
  longint cyc = 0, last_done_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        exp_drv[$];
  int          exp_bits[$];
  logic [31:0] exp_dat[$];
  string       exp_tag[$];
  logic [31:0] rsp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input int b);
    return (b >= 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
  endfunction

  function automatic void push_w(input int b, input logic [31:0] d, input string tag);
    exp_drv.push_back(1'b1); exp_bits.push_back(b);
    exp_dat.push_back(d & mask(b)); exp_tag.push_back(tag);
  endfunction

  function automatic void push_r(input int b, input logic [31:0] v, input string tag);
    exp_drv.push_back(1'b0); exp_bits.push_back(b);
    exp_dat.push_back('0); exp_tag.push_back(tag);
    rsp_q.push_back(v & mask(b));
  endfunction

  // bit engine and target model
  initial begin
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cmd_valid) begin
        logic        d0, e_d;
        logic [4:0]  l0;
        logic [31:0] dt0, rsp;
        int          e_b, lat;
        string       tg;
        d0 = cmd_drive; l0 = cmd_len; dt0 = cmd_data; rsp = '0;
        if (exp_drv.size() == 0) begin
          chk(1'b0, "R13", "unexpected command len", 64'(l0), 64'(0));
        end else begin
          e_d = exp_drv.pop_front(); e_b = exp_bits.pop_front(); tg = exp_tag.pop_front();
          chk(d0 == e_d, tg, "direction", 64'(d0), 64'(e_d));
          chk(int'(l0) + 1 == e_b, tg, "bit count", 64'(int'(l0) + 1), 64'(e_b));
          if (e_d) chk((dt0 & mask(e_b)) == exp_dat[0], tg, "driven bits",
                       64'(dt0 & mask(e_b)), 64'(exp_dat[0]));
          void'(exp_dat.pop_front());
          if (!e_d && rsp_q.size() > 0) rsp = rsp_q.pop_front();
        end
        lat = $urandom_range(0, 2);
        repeat (lat) @(negedge clk);
        chk(cmd_valid && cmd_drive == d0 && cmd_len == l0 && cmd_data == dt0,
            "R13", "held fields", 64'(cmd_len), 64'(l0));
        cmd_rdata = rsp;
        cmd_done = 1'b1;
        last_done_cyc = cyc;
      end
    end
  end

  task automatic run_txn(input logic [7:0] rq, input logic [31:0] wd, input logic [1:0] tc,
                         input logic [7:0] idl, input logic frc, input logic [2:0] ak,
                         input logic [31:0] rd, input logic bad, input bit mid);
    int turn_n, n, c;
    bit rnw, ok, wf, pe;
    logic [2:0] ack_exp;
    turn_n = int'(tc) + 1;
    rnw = rq[2];
    ok  = (ak == 3'b001);
    wf  = (ak == 3'b010) || (ak == 3'b100);
    push_w(8, {24'b0, rq}, "R2");
    push_r(turn_n + 3, (32'(ak) << turn_n) | ($urandom & mask(turn_n)), "R3");
    if (ok) begin
      if (rnw) begin
        push_r(32, rd, "R4");
        push_r(1, {31'b0, (^rd) ^ bad}, "R4");
        push_r(turn_n, $urandom, "R4");
      end else begin
        push_r(turn_n, $urandom, "R6");
        push_w(32, wd, "R6");
        push_w(1, {31'b0, ^wd}, "R6");
      end
      n = int'(idl);
      while (n > 0) begin
        c = (n > 32) ? 32 : n;
        push_w(c, '0, "R7");
        n -= c;
      end
    end else if (wf) begin
      if (frc && rnw) begin
        push_r(32, $urandom, "R8");
        push_r(1, $urandom, "R8");
      end
      push_r(turn_n, $urandom, frc ? "R8" : "R9");
      if (frc && !rnw) begin
        push_w(32, '0, "R8");
        push_w(1, '0, "R8");
      end
    end else begin
      push_r(32, $urandom, "R10");
      push_r(turn_n + 1, $urandom, "R10");
    end
    pe = ok && rnw && bad;
    ack_exp = pe ? 3'b000 : ak;

    @(negedge clk);
    req = rq; wdata = wd; turn = tc; idle = idl; force_dp = frc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'(1));
    if (mid) begin
      @(negedge clk);
      req = ~rq; wdata = ~wd; turn = ~tc; idle = 8'd3; force_dp = ~frc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(cyc - last_done_cyc == 1, "R11", "done latency", 64'(cyc - last_done_cyc), 64'(1));
    chk(ack == ack_exp, pe ? "R5" : "R3", "ack code", 64'(ack), 64'(ack_exp));
    chk(perr == pe, "R5", "parity flag", 64'(perr), 64'(pe));
    chk(rdata == ((ok && rnw) ? rd : 32'h0), "R4", "read word", 64'(rdata),
        64'((ok && rnw) ? rd : 32'h0));
    chk(exp_drv.size() == 0, "R13", "commands outstanding", 64'(exp_drv.size()), 64'(0));
    exp_drv.delete(); exp_bits.delete(); exp_dat.delete(); exp_tag.delete(); rsp_q.delete();
    @(negedge clk);
    chk(!done && !busy, "R11", "done width / busy drop", 64'({done, busy}), 64'(0));
    if (mid) begin
      repeat (3) begin
        @(negedge clk);
        chk(!busy && !cmd_valid, "R12", "no access after ignored start",
            64'({busy, cmd_valid}), 64'(0));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !perr, "R1", "reset flags",
        64'({busy, done, cmd_valid, perr}), 64'(0));
    chk(ack == 3'b000 && rdata == 32'h0, "R1", "reset data", 64'({ack, rdata}), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_txn(8'hA5, 32'h0, 2'd0, 8'd0,   1'b0, 3'b001, 32'h8000_0001, 1'b0, 0);
    run_txn(8'h81, 32'h1234_5678, 2'd3, 8'd32, 1'b0, 3'b001, 32'h0, 1'b0, 0);
    run_txn(8'h81, 32'hFFFF_0001, 2'd1, 8'd33, 1'b0, 3'b001, 32'h0, 1'b0, 0);
    run_txn(8'h8D, 32'h0, 2'd1, 8'd5,   1'b0, 3'b001, 32'h0F0F_1234, 1'b1, 0);
    run_txn(8'h8D, 32'h0, 2'd2, 8'd9,   1'b1, 3'b010, 32'h0, 1'b0, 0);
    run_txn(8'h81, 32'hCAFE_F00D, 2'd0, 8'd9, 1'b1, 3'b100, 32'h0, 1'b0, 0);
    run_txn(8'h81, 32'hCAFE_F00D, 2'd3, 8'd9, 1'b0, 3'b010, 32'h0, 1'b0, 0);
    run_txn(8'h8D, 32'h0, 2'd2, 8'd9,   1'b1, 3'b111, 32'h0, 1'b0, 0);
    run_txn(8'h81, 32'h0, 2'd3, 8'd9,   1'b0, 3'b000, 32'h0, 1'b0, 0);
    run_txn(8'h81, 32'h5555_AAAA, 2'd2, 8'd255, 1'b0, 3'b001, 32'h0, 1'b0, 1);

    for (int i = 0; i < 60; i++) begin
      logic [2:0] ak;
      int sel;
      sel = $urandom_range(0, 5);
      ak = (sel == 2) ? 3'b010 : (sel == 3) ? 3'b100 :
           (sel == 4) ? 3'($urandom) : 3'b001;
      run_txn(8'($urandom), $urandom, 2'($urandom), 8'($urandom_range(0, 80)),
              1'($urandom), ak, $urandom, ($urandom_range(0, 5) == 0), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule